// File: doc/BRIEF.md
# Pending-Acknowledge Destination Tracker

This block watches one chosen interrupt line and remembers which destinations were handed its last interrupt and have not yet returned an end-of-interrupt (EOI). It holds a one-bit-per-destination pending map and a count of the set bits. While the count is nonzero, the line is held off: a fresh request on it is reported as coalesced instead of being forwarded.

The delivery logic outside the block tells it which destinations accepted an interrupt. Each destination's EOI then clears its own bit. A restore port writes the wanted pending state of a single destination, so that the map can be rebuilt after the state has been saved elsewhere. A tracking-clear input empties the map. Picking the destinations is done elsewhere.

Top module: `pet_tracker`

## Requirements
- R1: With `rst_n` low, or with `trk_clear_i` high, at a clock edge, the map and the count are both zero after that edge. Clear wins over every other input in the same cycle.
- R2: `coalesce_o` is high exactly when the count is nonzero. With `line_req_i` high, `fwd_o` equals `!coalesce_o` and `drop_o` equals `coalesce_o`. Both are zero when `line_req_i` is low. All three outputs are combinational from the current state.
- R3: A delivery (`dlv_valid_i`) while the count is zero loads the map with `dlv_map_i`, where bit i stands for destination i. It loads the count with the number of ones in `dlv_map_i`. An all-zero map gives a count of zero.
- R4: A delivery while the count is nonzero raises `dlv_err_o` in that same cycle and is discarded. An EOI or restore in that cycle is still applied.
- R5: An EOI for a destination whose bit is set clears that bit and lowers the count by one.
- R6: An EOI for a destination whose bit is clear changes neither the map nor the count.
- R7: A restore with a `rsto_pend_i` value equal to the destination's bit changes nothing. Otherwise it sets the bit and adds one to the count, or it clears the bit and subtracts one.
- R8: In the cycle of an accepted delivery, any EOI and any restore are ignored.
- R9: When a restore and an EOI name the same destination in one cycle, the restore value decides the bit.
- R10: The count never goes below zero and always equals the number of set bits in the map, up to the full 16. A 16-destination delivery gives a count of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trk_clear_i | input | 1 | Empty the map and the count |
| line_req_i | input | 1 | New assertion on the tracked line |
| dlv_valid_i | input | 1 | Delivery event |
| dlv_map_i | input | 16 | Destinations that accepted the delivery |
| eoi_valid_i | input | 1 | EOI event |
| eoi_dest_i | input | 4 | Destination sending the EOI |
| rsto_valid_i | input | 1 | Restore event |
| rsto_dest_i | input | 4 | Destination being restored |
| rsto_pend_i | input | 1 | Wanted pending state for that destination |
| pend_map_o | output | 16 | Current pending map |
| pend_cnt_o | output | 5 | Current pending count |
| coalesce_o | output | 1 | Acknowledgements are outstanding |
| fwd_o | output | 1 | Request on the line may be forwarded |
| drop_o | output | 1 | Request on the line is coalesced |
| dlv_err_o | output | 1 | Delivery made while the count is nonzero |

## Verification
The map and the count are registered. Any delivery, EOI, restore or clear therefore shows up on `pend_map_o` and `pend_cnt_o` one edge after it is driven. The bench drives at a falling edge and reads these outputs at the following falling edge. `fwd_o`, `drop_o` and `dlv_err_o` depend on the inputs and the current state in the same cycle. They are read a short delay after the inputs are driven, before the edge that consumes those inputs.

// File: rtl/pet_pkg.sv
// Package: shared sizes for the pending-acknowledge tracker.
// Assumes the destination count is a power of two so the index width is exact.
package pet_pkg;
    parameter int unsigned DESTS = 16;
    localparam int unsigned IDX_W = $clog2(DESTS);
    localparam int unsigned CNT_W = $clog2(DESTS + 1);
endpackage

// File: rtl/pet_popcnt.sv
// pet_popcnt: combinational count of set bits in a vector.
// Assumes OUT_W is wide enough to hold W.
module pet_popcnt #(
    parameter int unsigned W     = 16,
    parameter int unsigned OUT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [OUT_W-1:0] cnt_o
);
    // Add up the bits one at a time.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < int'(W); i++) begin
            cnt_o = cnt_o + OUT_W'(vec_i[i]);
        end
    end
endmodule

// File: rtl/pet_slot.sv
// pet_slot: the pending bit of one destination.
// The priority order is clear, then load, then restore, then EOI.
// inc_o and dec_o report one-step changes made by restore or EOI. They are
// zero in clear and load cycles, because the count is loaded whole in those.
module pet_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic load_i,
    input  logic load_bit_i,
    input  logic rsto_i,
    input  logic rsto_bit_i,
    input  logic eoi_i,
    output logic bit_o,
    output logic inc_o,
    output logic dec_o
);
    logic nxt;

    // Choose the next bit value by priority.
    always_comb begin
        if (clear_i)     nxt = 1'b0;
        else if (load_i) nxt = load_bit_i;
        else if (rsto_i) nxt = rsto_bit_i;
        else if (eoi_i)  nxt = 1'b0;
        else             nxt = bit_o;
    end

    // Flag one-step changes for the count adder.
    always_comb begin
        inc_o = !clear_i && !load_i && !bit_o && nxt;
        dec_o = !clear_i && !load_i && bit_o && !nxt;
    end

    // Hold the pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_o <= 1'b0;
        else        bit_o <= nxt;
    end

    // R7
    restore_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsto_i && !load_i && !clear_i) |=> (bit_o == $past(rsto_bit_i)));

    // R6
    eoi_clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !rsto_i && !load_i && !clear_i && !bit_o) |=> !bit_o);
endmodule

// File: rtl/pet_tracker.sv
// pet_tracker: pending-acknowledge tracker for one interrupt line.
// It keeps one slot per destination and a registered count that always equals
// the number of set slots. A delivery is accepted only while the count is zero.
// Assumes at most one EOI and one restore per cycle.
module pet_tracker
    import pet_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trk_clear_i,
    input  logic             line_req_i,
    input  logic             dlv_valid_i,
    input  logic [DESTS-1:0] dlv_map_i,
    input  logic             eoi_valid_i,
    input  logic [IDX_W-1:0] eoi_dest_i,
    input  logic             rsto_valid_i,
    input  logic [IDX_W-1:0] rsto_dest_i,
    input  logic             rsto_pend_i,
    output logic [DESTS-1:0] pend_map_o,
    output logic [CNT_W-1:0] pend_cnt_o,
    output logic             coalesce_o,
    output logic             fwd_o,
    output logic             drop_o,
    output logic             dlv_err_o
);
    logic             dlv_ok;
    logic [DESTS-1:0] inc_v, dec_v;
    logic [CNT_W-1:0] load_cnt, n_inc, n_dec, cnt_nxt;

    // Decide whether this cycle's delivery is legal.
    always_comb begin
        dlv_ok    = dlv_valid_i && (pend_cnt_o == '0) && !trk_clear_i;
        dlv_err_o = dlv_valid_i && (pend_cnt_o != '0);
    end

    // Build one slot per destination.
    for (genvar g = 0; g < int'(DESTS); g++) begin : g_slot
        pet_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_i    (trk_clear_i),
            .load_i     (dlv_ok),
            .load_bit_i (dlv_map_i[g]),
            .rsto_i     (rsto_valid_i && (rsto_dest_i == IDX_W'(g))),
            .rsto_bit_i (rsto_pend_i),
            .eoi_i      (eoi_valid_i && (eoi_dest_i == IDX_W'(g))),
            .bit_o      (pend_map_o[g]),
            .inc_o      (inc_v[g]),
            .dec_o      (dec_v[g])
        );
    end

    pet_popcnt #(.W(DESTS), .OUT_W(CNT_W)) u_pc_load (.vec_i(dlv_map_i), .cnt_o(load_cnt));
    pet_popcnt #(.W(DESTS), .OUT_W(CNT_W)) u_pc_inc  (.vec_i(inc_v),     .cnt_o(n_inc));
    pet_popcnt #(.W(DESTS), .OUT_W(CNT_W)) u_pc_dec  (.vec_i(dec_v),     .cnt_o(n_dec));

    // Work out the next count: clear, whole load, or one-step adjust.
    always_comb begin
        if (trk_clear_i) cnt_nxt = '0;
        else if (dlv_ok) cnt_nxt = load_cnt;
        else             cnt_nxt = pend_cnt_o + n_inc - n_dec;
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_cnt_o <= '0;
        else        pend_cnt_o <= cnt_nxt;
    end

    // Gate requests on the tracked line.
    always_comb begin
        coalesce_o = (pend_cnt_o != '0);
        fwd_o      = line_req_i && !coalesce_o;
        drop_o     = line_req_i && coalesce_o;
    end

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trk_clear_i && !dlv_ok) |-> (int'(pend_cnt_o) + int'(n_inc) >= int'(n_dec)));

    // R10
    count_matches_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_cnt_o) == $countones(pend_map_o));

    // R1
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_clear_i |=> (pend_map_o == '0 && pend_cnt_o == '0));

    // R3
    delivery_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid_i && pend_cnt_o == '0 && !trk_clear_i) |=> (pend_map_o == $past(dlv_map_i)));

    // R2
    coalesce_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coalesce_o |-> (pend_map_o != '0));

    // R5
    eoi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid_i && pend_map_o[eoi_dest_i] && !trk_clear_i && !dlv_ok &&
         !(rsto_valid_i && rsto_dest_i == eoi_dest_i))
        |=> !pend_map_o[$past(eoi_dest_i)]);
endmodule

// File: tb/pet_tracker_test.sv
`timescale 1ns/100ps
module pet_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trk_clear_i = 1'b0, line_req_i = 1'b0, dlv_valid_i = 1'b0;
    logic [15:0] dlv_map_i = '0;
    logic        eoi_valid_i = 1'b0, rsto_valid_i = 1'b0, rsto_pend_i = 1'b0;
    logic [3:0]  eoi_dest_i = '0, rsto_dest_i = '0;
    logic [15:0] pend_map_o;
    logic [4:0]  pend_cnt_o;
    logic        coalesce_o, fwd_o, drop_o, dlv_err_o;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    pet_tracker uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        trk_clear_i = 0; dlv_valid_i = 0; eoi_valid_i = 0; rsto_valid_i = 0; line_req_i = 0;
    endtask

    // Let one edge consume the driven inputs, then return to idle inputs.
    task automatic step();
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic state(input string req, input int m, input int c);
        chk({req, " map"}, pend_map_o, m);
        chk({req, " cnt"}, pend_cnt_o, c);
    endtask

    task automatic eoi(input int d);
        eoi_valid_i = 1; eoi_dest_i = 4'(d); step();
    endtask

    task automatic rsto(input int d, input logic p);
        rsto_valid_i = 1; rsto_dest_i = 4'(d); rsto_pend_i = p; step();
    endtask

    task automatic t_reset();
        state("R1 reset", 0, 0);
        chk("R2 coalesce idle", coalesce_o, 0);
        line_req_i = 1; #1;
        chk("R2 fwd idle", fwd_o, 1); chk("R2 drop idle", drop_o, 0);
        idle();
    endtask

    task automatic t_deliver();
        dlv_valid_i = 1; dlv_map_i = 16'h8421; #1;
        chk("R4 no err legal", dlv_err_o, 0);
        step();
        state("R3 load", 16'h8421, 4);
        chk("R2 coalesce busy", coalesce_o, 1);
        line_req_i = 1; #1;
        chk("R2 drop busy", drop_o, 1); chk("R2 fwd busy", fwd_o, 0);
        idle();
    endtask

    task automatic t_eoi();
        eoi(0);  state("R5 eoi hit", 16'h8420, 3);
        eoi(1);  state("R6 eoi miss", 16'h8420, 3);
    endtask

    task automatic t_illegal();
        dlv_valid_i = 1; dlv_map_i = 16'hFFFF; eoi_valid_i = 1; eoi_dest_i = 4'd5; #1;
        chk("R4 err", dlv_err_o, 1);
        step();
        state("R4 dropped", 16'h8400, 2);
    endtask

    task automatic t_restore();
        rsto(2, 1);  state("R7 set", 16'h8404, 3);
        rsto(2, 1);  state("R7 equal", 16'h8404, 3);
        rsto(15, 0); state("R7 clear", 16'h0404, 2);
    endtask

    task automatic t_same_dest();
        rsto_valid_i = 1; rsto_dest_i = 4'd3; rsto_pend_i = 1;
        eoi_valid_i = 1; eoi_dest_i = 4'd3; step();
        state("R9 restore wins", 16'h040C, 3);
        eoi(2); eoi(3); eoi(10);
        state("R5 drained", 0, 0);
        chk("R2 coalesce drained", coalesce_o, 0);
    endtask

    task automatic t_priority();
        dlv_valid_i = 1; dlv_map_i = 16'h00F0; eoi_valid_i = 1; eoi_dest_i = 4'd4;
        rsto_valid_i = 1; rsto_dest_i = 4'd0; rsto_pend_i = 1; step();
        state("R8 delivery first", 16'h00F0, 4);
    endtask

    task automatic t_clear_full();
        trk_clear_i = 1; dlv_valid_i = 1; dlv_map_i = 16'h0F0F; step();
        state("R1 clear", 0, 0);
        dlv_valid_i = 1; dlv_map_i = 16'hFFFF; step();
        state("R10 full", 16'hFFFF, 16);
        for (int d = 0; d < 16; d++) eoi(d);
        state("R10 emptied", 0, 0);
        eoi(0);
        state("R10 no negative", 0, 0);
        dlv_valid_i = 1; dlv_map_i = 16'h0000; step();
        state("R3 empty map", 0, 0);
        chk("R3 empty coalesce", coalesce_o, 0);
    endtask

    task automatic t_midreset();
        dlv_valid_i = 1; dlv_map_i = 16'h1111; step();
        rst_n = 0; step(); rst_n = 1;
        state("R1 reset mid run", 0, 0);
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
        t_reset(); t_deliver(); t_eoi(); t_illegal(); t_restore();
        t_same_dest(); t_priority(); t_clear_full(); t_midreset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule